// File: doc/BRIEF.md
# SCL Stall and Stuck-High Timeout Monitor

This block watches the clock line of an I2C bus and reports two faults. One is the line being held low for too long, as happens when a target stretches the clock without end. The other is the line staying high for too long. Each fault has its own 12-bit down-counter. Both counters step on a prescaled tick whose period is `(1 + tpr) * 12` module clocks. Software sets an 8-bit limit for each counter. That limit fills the upper bits of the counter, and the low nibble is always zero. A limit of 0x00 or 0x01 turns the check off.

A counter reloads from its limit while the line sits at the opposite level. It counts down once the line moves to the level it watches. When the count runs out, the block sets a sticky flag and gives a one-cycle interrupt pulse. The flag stays set until the protocol engine reports an idle bus, software pulses a clear, or reset. Both bus lines pass through a two-flop synchronizer. Their synchronized levels are also driven out so software can see the state of the bus.

Top module: `scl_timeout_mon`

## Requirements
- R1: `mon_scl` and `mon_sda` show the levels of `scl_in` and `sda_in` two clock edges after they change.
- R2: One tick is `(tpr + 1) * 12` clocks, and the low counter's load value is `lim_lo * 16`. An input driven low between two edges sets `to_lo_flag` after exactly `2 + lim_lo*16*(tpr+1)*12` rising edges, and not one edge earlier.
- R3: The low counter reloads while the synchronized SCL is high. A high pulse on SCL makes the next low period start again from the full limit.
- R4: A limit of 0x00 or 0x01 disables its timeout, so its flag never sets however long the level lasts.
- R5: The high counter works the same way, measured while SCL is high, with `lim_hi` and `to_hi_flag`, and it reloads while SCL is low.
- R6: A flag is sticky. It stays set after SCL changes level. It clears one edge after `bus_idle` or `flag_clr` is high. A clear in the same cycle as an expiry wins, so the flag stays at 0.
- R7: `to_lo_irq` or `to_hi_irq` is high for exactly the one cycle in which its flag goes from 0 to 1.
- R8: A counter that has reached zero holds there until it reloads. After its flag is cleared, the flag does not set again while SCL stays at the same level.
- R9: After reset, both flags and both interrupts are 0, and both monitor outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw clock line from the pad |
| sda_in | input | 1 | Raw data line from the pad |
| tpr | input | 8 | Timer period; tick = (tpr+1)*12 clocks |
| lim_lo | input | 8 | Upper 8 bits of the low-timeout load value |
| lim_hi | input | 8 | Upper 8 bits of the high-timeout load value |
| bus_idle | input | 1 | Idle indication from the protocol engine; clears both flags |
| flag_clr | input | 1 | Software clear strobe for both flags |
| to_lo_flag | output | 1 | Sticky flag: SCL held low too long |
| to_hi_flag | output | 1 | Sticky flag: SCL held high too long |
| to_lo_irq | output | 1 | One-cycle pulse when to_lo_flag sets |
| to_hi_irq | output | 1 | One-cycle pulse when to_hi_flag sets |
| mon_scl | output | 1 | Synchronized SCL level |
| mon_sda | output | 1 | Synchronized SDA level |

## Verification
The bench sweeps several limits and timer periods for both counters. It checks the flag one edge before and exactly at the computed expiry edge. This catches a design that loses the synchronizer latency or mis-sizes the tick, which would shift the expiry by one or more cycles. A high pulse in the middle of a low period must restart the full count; a design that only paused the counter would expire early. The limits 0x00 and 0x01 are held far past their nominal period to catch a wrong enable comparison. A clear driven into the exact expiry cycle, followed by a long wait at the same level, exposes a design that lets the set win over the clear or that wraps the counter past zero and fires again.

// File: rtl/scl_to_pkg.sv
package scl_to_pkg;
  localparam int TICK_MUL = 12;
  localparam int NUM_CHAN = 2;

  function automatic logic [11:0] load_of(input logic [7:0] lim);
    return {lim, 4'h0};
  endfunction
endpackage

// File: rtl/scl_to_sync.sv
module scl_to_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic stg1_q, stg2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg1_q <= 1'b1;
        stg2_q <= 1'b1;
      end else begin
        stg1_q <= d_in[i];
        stg2_q <= stg1_q;
      end
    end
    assign d_out[i] = stg2_q;
  end
endmodule

// File: rtl/scl_to_prescale.sv
module scl_to_prescale #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] top,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q, cnt_n;
  logic             at_top;

  always_comb begin
    at_top = (cnt_q == top);
    tick   = !restart && at_top;
    if (restart)     cnt_n = '0;
    else if (at_top) cnt_n = '0;
    else             cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/scl_to_chan.sv
module scl_to_chan #(
  parameter int   CNT_W   = 12,
  parameter int   LIM_W   = 8,
  parameter int   PRE_W   = 12,
  parameter logic ACT_LVL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_lvl,
  input  logic [LIM_W-1:0] lim,
  input  logic [PRE_W-1:0] pre_top,
  input  logic             clr,
  output logic             flag,
  output logic             irq
);
  localparam int PAD_W = CNT_W - LIM_W;

  logic             active, tick, enabled, expire;
  logic [CNT_W-1:0] load_val, cnt_q, cnt_n;
  logic             flag_q, flag_n, irq_q, irq_n;

  scl_to_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (!active),
    .top     (pre_top),
    .tick    (tick)
  );

  always_comb begin
    active   = (scl_lvl == ACT_LVL);
    load_val = {lim, {PAD_W{1'b0}}};
    enabled  = (lim > LIM_W'(1));
    expire   = active && tick && enabled && (cnt_q == CNT_W'(1));

    if (!active)                  cnt_n = load_val;
    else if (tick && cnt_q != '0) cnt_n = cnt_q - 1'b1;
    else                          cnt_n = cnt_q;

    flag_n = clr ? 1'b0 : (flag_q | expire);
    irq_n  = expire && !flag_q && !clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      flag_q <= flag_n;
      irq_q  <= irq_n;
    end
  end

  assign flag = flag_q;
  assign irq  = irq_q;
endmodule

// File: rtl/scl_timeout_mon.sv
module scl_timeout_mon
  import scl_to_pkg::*;
#(
  parameter int TPR_W = 8,
  parameter int LIM_W = 8,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [TPR_W-1:0] tpr,
  input  logic [LIM_W-1:0] lim_lo,
  input  logic [LIM_W-1:0] lim_hi,
  input  logic             bus_idle,
  input  logic             flag_clr,
  output logic             to_lo_flag,
  output logic             to_hi_flag,
  output logic             to_lo_irq,
  output logic             to_hi_irq,
  output logic             mon_scl,
  output logic             mon_sda
);
  localparam int PRE_W = TPR_W + 4;

  logic [1:0]          sync_out;
  logic [PRE_W-1:0]    tpr_p1, pre_top;
  logic                clr_all;
  logic [LIM_W-1:0]    lim_arr  [NUM_CHAN];
  logic [NUM_CHAN-1:0] flag_arr, irq_arr;

  scl_to_sync #(.WIDTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({sda_in, scl_in}),
    .d_out (sync_out)
  );

  always_comb begin
    tpr_p1     = PRE_W'(tpr) + 1'b1;
    pre_top    = tpr_p1 * PRE_W'(TICK_MUL) - 1'b1;
    clr_all    = bus_idle | flag_clr;
    lim_arr[0] = lim_lo;
    lim_arr[1] = lim_hi;
  end

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    scl_to_chan #(
      .CNT_W   (CNT_W),
      .LIM_W   (LIM_W),
      .PRE_W   (PRE_W),
      .ACT_LVL ((c == 0) ? 1'b0 : 1'b1)
    ) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_lvl (sync_out[0]),
      .lim     (lim_arr[c]),
      .pre_top (pre_top),
      .clr     (clr_all),
      .flag    (flag_arr[c]),
      .irq     (irq_arr[c])
    );
  end

  assign mon_scl    = sync_out[0];
  assign mon_sda    = sync_out[1];
  assign to_lo_flag = flag_arr[0];
  assign to_hi_flag = flag_arr[1];
  assign to_lo_irq  = irq_arr[0];
  assign to_hi_irq  = irq_arr[1];
endmodule

// File: rtl/scl_timeout_mon_chk.sv
module scl_timeout_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] lim_lo,
  input logic [7:0] lim_hi,
  input logic       bus_idle,
  input logic       flag_clr,
  input logic       to_lo_flag,
  input logic       to_hi_flag,
  input logic       to_lo_irq,
  input logic       to_hi_irq,
  input logic       mon_scl
);
  assert_lo_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_lo_flag) |-> ($past(lim_lo) > 8'd1));
  assert_hi_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_hi_flag) |-> ($past(lim_hi) > 8'd1));
  assert_lo_rise_while_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_lo_flag) |-> !$past(mon_scl));
  assert_hi_rise_while_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_hi_flag) |-> $past(mon_scl));
  assert_flags_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle || flag_clr) |=> (!to_lo_flag && !to_hi_flag));
  assert_lo_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (to_lo_flag && !bus_idle && !flag_clr) |=> to_lo_flag);
  assert_hi_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (to_hi_flag && !bus_idle && !flag_clr) |=> to_hi_flag);
  assert_lo_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    to_lo_irq |-> (to_lo_flag && !$past(to_lo_flag)));
  assert_hi_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    to_hi_irq |-> (to_hi_flag && !$past(to_hi_flag)));
  assert_lo_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    to_lo_irq |=> !to_lo_irq);
endmodule

bind scl_timeout_mon scl_timeout_mon_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lim_lo     (lim_lo),
  .lim_hi     (lim_hi),
  .bus_idle   (bus_idle),
  .flag_clr   (flag_clr),
  .to_lo_flag (to_lo_flag),
  .to_hi_flag (to_hi_flag),
  .to_lo_irq  (to_lo_irq),
  .to_hi_irq  (to_hi_irq),
  .mon_scl    (mon_scl)
);

// File: tb/scl_timeout_mon_bench.sv
`timescale 1ns/1ps
module scl_timeout_mon_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_in, sda_in, bus_idle, flag_clr;
  logic [7:0] tpr, lim_lo, lim_hi;
  logic       to_lo_flag, to_hi_flag, to_lo_irq, to_hi_irq, mon_scl, mon_sda;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  scl_timeout_mon u_scl_timeout_mon (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .tpr(tpr),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .bus_idle(bus_idle), .flag_clr(flag_clr),
    .to_lo_flag(to_lo_flag), .to_hi_flag(to_hi_flag), .to_lo_irq(to_lo_irq),
    .to_hi_irq(to_hi_irq), .mon_scl(mon_scl), .mon_sda(mon_sda)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int flag_of(input int ch);
    return (ch == 0) ? int'(to_lo_flag) : int'(to_hi_flag);
  endfunction
  function automatic int irq_of(input int ch);
    return (ch == 0) ? int'(to_lo_irq) : int'(to_hi_irq);
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Put channel ch in its reload state with the given config, flags cleared.
  task automatic prep(input int ch, input int lim, input int tp);
    tpr      = 8'(tp);
    lim_lo   = (ch == 0) ? 8'(lim) : 8'h00;
    lim_hi   = (ch == 1) ? 8'(lim) : 8'h00;
    scl_in   = (ch == 0) ? 1'b1 : 1'b0;
    flag_clr = 1'b1;
    cycles(1);
    flag_clr = 1'b0;
    cycles(4);
  endtask

  // R2 / R5 / R7 exact expiry timing
  task automatic timed_run(input int ch, input int lim, input int tp, input string req);
    int lp;
    lp = lim * 16 * (tp + 1) * 12;
    prep(ch, lim, tp);
    scl_in = (ch == 0) ? 1'b0 : 1'b1;
    cycles(1 + lp);
    chk(req, $sformatf("flag one edge early lim=%0d tpr=%0d", lim, tp), flag_of(ch), 0);
    cycles(1);
    chk(req, $sformatf("flag at expiry lim=%0d tpr=%0d", lim, tp), flag_of(ch), 1);
    chk("R7", "irq at expiry", irq_of(ch), 1);
    cycles(1);
    chk("R7", "irq one cycle only", irq_of(ch), 0);
    chk("R6", "flag held", flag_of(ch), 1);
  endtask

  initial begin
    rst_n = 1'b0; scl_in = 1'b1; sda_in = 1'b1; bus_idle = 1'b0; flag_clr = 1'b0;
    tpr = 8'd0; lim_lo = 8'd0; lim_hi = 8'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cycles(1);

    // R9 reset state
    chk("R9", "to_lo_flag", to_lo_flag, 0);
    chk("R9", "to_hi_flag", to_hi_flag, 0);
    chk("R9", "irqs", int'(to_lo_irq | to_hi_irq), 0);
    chk("R9", "mon_scl", mon_scl, 1);
    chk("R9", "mon_sda", mon_sda, 1);

    // R1 two-edge synchronizer latency on both lines
    sda_in = 1'b0; cycles(1);
    chk("R1", "mon_sda after 1 edge", mon_sda, 1);
    cycles(1);
    chk("R1", "mon_sda after 2 edges", mon_sda, 0);
    scl_in = 1'b0; cycles(1);
    chk("R1", "mon_scl after 1 edge", mon_scl, 1);
    cycles(1);
    chk("R1", "mon_scl after 2 edges", mon_scl, 0);
    sda_in = 1'b1; scl_in = 1'b1; cycles(4);

    // R2 sweep of the low counter, R5 sweep of the high counter
    for (int lim = 2; lim <= 3; lim++)
      for (int tp = 0; tp <= 2; tp++) begin
        timed_run(0, lim, tp, "R2");
        timed_run(1, lim, tp, "R5");
      end

    // R2 large limit: 0xDA loads 0xDA0 = 3488 counts
    timed_run(0, 8'hDA, 0, "R2");

    // R6 sticky across level change, then bus_idle clear
    scl_in = 1'b1; cycles(6);
    chk("R6", "flag stays after SCL high", to_lo_flag, 1);
    bus_idle = 1'b1; cycles(1); bus_idle = 1'b0;
    chk("R6", "bus_idle clears flag", to_lo_flag, 0);

    // R3 high pulse restarts the full low period
    begin
      int lp = 2 * 16 * 12;
      prep(0, 2, 0);
      scl_in = 1'b0; cycles(lp - 20);
      scl_in = 1'b1; cycles(4);
      scl_in = 1'b0; cycles(1 + lp);
      chk("R3", "no expiry before restarted period", to_lo_flag, 0);
      cycles(1);
      chk("R3", "expiry after restarted period", to_lo_flag, 1);
    end

    // R6 + R8: clear into the expiry cycle wins; counter holds at zero
    begin
      int lp = 2 * 16 * 12;
      prep(0, 2, 0);
      scl_in = 1'b0; cycles(1 + lp);
      flag_clr = 1'b1; cycles(1); flag_clr = 1'b0;
      chk("R6", "clear wins over expiry", to_lo_flag, 0);
      chk("R7", "no irq when clear wins", to_lo_irq, 0);
      cycles(lp + 50);
      chk("R8", "held at zero, no re-expiry", to_lo_flag, 0);
    end

    // R8 after a normal expiry and clear, still low: stays clear
    timed_run(0, 2, 0, "R2");
    flag_clr = 1'b1; cycles(1); flag_clr = 1'b0;
    cycles(2 * 16 * 12 + 50);
    chk("R8", "no second expiry on same low", to_lo_flag, 0);

    // R4 disabled limits
    for (int lim = 0; lim <= 1; lim++) begin
      prep(0, lim, 0);
      scl_in = 1'b0; cycles(2 * 16 * 12 + 100);
      chk("R4", $sformatf("low disabled lim=%0d", lim), to_lo_flag, 0);
      prep(1, lim, 0);
      scl_in = 1'b1; cycles(2 * 16 * 12 + 100);
      chk("R4", $sformatf("high disabled lim=%0d", lim), to_hi_flag, 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule